// File: doc/BRIEF.md
# DTMF Detection Timing Qualifier

This block sits behind a dual-tone frequency analyser. Each millisecond the analyser reports whether a valid tone pair is present and which of the sixteen digits it decoded. The block turns that noisy, per-sample evidence into a stable receive-data register and an active-low "tone present" flag that software can poll. All timing is counted in ticks of a 1 ms enable, `tick`. The block does nothing on clock edges where `tick` is low.

The qualifier discards bursts that are too short. It tolerates short drop-outs, with one allowance while the digit is still being qualified and another once the flag is low. It loads the digit after the detect time. It lowers the flag a fixed number of ticks after the data appears, so that software can latch the data on the falling edge of the flag. When the tone stays away for the hold time, the flag returns high. The data is cleared only after a full interdigit pause. A tone that returns before that pause lowers the flag again and leaves the earlier data in place.

Two threshold sets, normal and fast, are chosen by `fast_mode`. The normal set tolerates signal repetition down to about 90 ms and the fast set down to about 60 ms.

Top module: `dtmf_timing_qual`

## Requirements
- R1: After `rst` (synchronous, active high), `present_n` is 1 and `rx_data` is 0. All timers restart, so a tone that starts after reset must again be present for the full detect time before it is accepted.
- R2: From idle, if the tone is valid on `det` consecutive ticks, `rx_data` takes the digit captured on the first tick. The change appears on the tick that is number `det`, and not on any earlier tick. `det` is 37 in normal mode and 24 in fast mode.
- R3: `present_n` falls on the tick that comes `spd` ticks after the tick on which `rx_data` was loaded, with `spd` = 3. Before that tick it stays 1.
- R4: A burst of `rej` ticks or fewer is dropped on its first absent tick, and neither output changes. `rej` is 26 in normal mode and 12 in fast mode.
- R5: While a digit is being qualified, a gap of at most `drop1` absent ticks (10 in both modes) after a burst longer than `rej` is bridged. The absent ticks count toward `det`. A gap of `drop1`+1 ticks abandons the attempt, and a later tone needs the full `det` ticks again.
- R6: After `present_n` has fallen, a gap of at most `drop2` absent ticks leaves both `present_n` and `rx_data` unchanged. `drop2` is 20 in normal mode and 15 in fast mode.
- R7: After `present_n` has fallen, the absent tick numbered `drop2`+1 raises `present_n` to 1, and `rx_data` keeps its value.
- R8: `rx_data` clears to 0 only on the absent tick numbered `pause`, counted from the start of the gap. `pause` is 30 in normal mode and 24 in fast mode.
- R9: A tone that returns after release but before `pause` lowers `present_n` on that tick and leaves `rx_data` unchanged, even if the digit differs.
- R10: `fast_mode` = 1 selects the fast thresholds and `fast_mode` = 0 selects the normal ones.
- R11: The outputs change only on clock edges where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse every 1 ms; timing advances only on these |
| fast_mode | input | 1 | 0 selects normal thresholds, 1 selects fast thresholds |
| tone_valid | input | 1 | Analyser reports a valid tone pair on this tick |
| tone_digit | input | 4 | Digit code from the analyser |
| rx_data | output | 4 | Qualified receive digit, 0 when cleared |
| present_n | output | 1 | Active-low tone-present flag |

## Verification
The assertions assume that `rst` is held for several cycles at start-up. They also assume that the thresholds keep the order rej < det, drop1 < pause and drop2 + 1 < pause, with det, spd and both drop-out allowances at least 1. The stimulus changes `tone_valid` and `tone_digit` only while `tick` is low. It changes `fast_mode` only while the block is idle, with clock cycles to spare before the next tick, so one threshold set governs each tone from start to finish.

// File: rtl/dtmf_tq_pkg.sv
package dtmf_tq_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_QUAL = 3'd1,
    S_GAP1 = 3'd2,
    S_ACC  = 3'd3,
    S_GAP2 = 3'd4,
    S_REL  = 3'd5
  } qstate_t;
endpackage

// File: rtl/dtmf_tq_profile.sv
module dtmf_tq_profile #(
  parameter int TW      = 8,
  parameter int NRM_DET = 37, parameter int FST_DET = 24,
  parameter int NRM_REJ = 26, parameter int FST_REJ = 12,
  parameter int NRM_DR1 = 10, parameter int FST_DR1 = 10,
  parameter int NRM_DR2 = 20, parameter int FST_DR2 = 15,
  parameter int NRM_PAU = 30, parameter int FST_PAU = 24,
  parameter int NRM_SPD = 3,  parameter int FST_SPD = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fast_mode,
  output logic [TW-1:0] det,
  output logic [TW-1:0] rej,
  output logic [TW-1:0] drop1,
  output logic [TW-1:0] drop2,
  output logic [TW-1:0] pause,
  output logic [TW-1:0] spd
);
  localparam int NUM_SET = 2;
  localparam int VAL_PER = 6;

  logic [TW-1:0] tbl [NUM_SET][VAL_PER];

  assign tbl[0][0] = TW'(NRM_DET);
  assign tbl[0][1] = TW'(NRM_REJ);
  assign tbl[0][2] = TW'(NRM_DR1);
  assign tbl[0][3] = TW'(NRM_DR2);
  assign tbl[0][4] = TW'(NRM_PAU);
  assign tbl[0][5] = TW'(NRM_SPD);
  assign tbl[1][0] = TW'(FST_DET);
  assign tbl[1][1] = TW'(FST_REJ);
  assign tbl[1][2] = TW'(FST_DR1);
  assign tbl[1][3] = TW'(FST_DR2);
  assign tbl[1][4] = TW'(FST_PAU);
  assign tbl[1][5] = TW'(FST_SPD);

  logic sel;

  always_ff @(posedge clk) begin
    if (rst) sel <= 1'b0;
    else     sel <= fast_mode;
  end

  assign det   = tbl[sel][0];
  assign rej   = tbl[sel][1];
  assign drop1 = tbl[sel][2];
  assign drop2 = tbl[sel][3];
  assign pause = tbl[sel][4];
  assign spd   = tbl[sel][5];
endmodule

// File: rtl/dtmf_tq_fsm.sv
module dtmf_tq_fsm
  import dtmf_tq_pkg::*;
#(
  parameter int TW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          tone_valid,
  input  logic [DW-1:0] tone_digit,
  input  logic          present_n,
  input  logic [TW-1:0] det,
  input  logic [TW-1:0] rej,
  input  logic [TW-1:0] drop1,
  input  logic [TW-1:0] drop2,
  input  logic [TW-1:0] pause,
  input  logic [TW-1:0] spd,
  output qstate_t       state,
  output logic          load,
  output logic [DW-1:0] load_data,
  output logic          clr,
  output logic          flag_set,
  output logic          flag_clr
);
  localparam logic [TW-1:0] ONE = TW'(1);

  qstate_t       st_q, st_d;
  logic [TW-1:0] el_q, el_d;
  logic [TW-1:0] gp_q, gp_d;
  logic [TW-1:0] sp_q, sp_d;
  logic [DW-1:0] dg_q, dg_d;
  logic [TW-1:0] lim;

  always_comb begin
    st_d     = st_q;
    el_d     = el_q;
    gp_d     = gp_q;
    sp_d     = sp_q;
    dg_d     = dg_q;
    load     = 1'b0;
    clr      = 1'b0;
    flag_set = 1'b0;
    flag_clr = 1'b0;
    lim      = present_n ? drop1 : drop2;
    if (tick) begin
      unique case (st_q)
        S_IDLE: begin
          if (tone_valid) begin
            st_d = S_QUAL;
            el_d = ONE;
            dg_d = tone_digit;
          end
        end
        S_QUAL, S_GAP1: begin
          if (tone_valid) begin
            if (el_q + ONE >= det) begin
              load = 1'b1;
              st_d = S_ACC;
              sp_d = '0;
              gp_d = '0;
            end else begin
              el_d = el_q + ONE;
              st_d = S_QUAL;
            end
          end else if (st_q == S_QUAL) begin
            if (el_q <= rej) begin
              st_d = S_IDLE;
            end else begin
              st_d = S_GAP1;
              gp_d = ONE;
              el_d = el_q + ONE;
            end
          end else if (gp_q >= drop1) begin
            st_d = S_IDLE;
          end else begin
            gp_d = gp_q + ONE;
            el_d = el_q + ONE;
          end
        end
        S_ACC: begin
          if (!tone_valid) begin
            st_d = S_GAP2;
            gp_d = ONE;
          end
        end
        S_GAP2: begin
          if (tone_valid) begin
            st_d = S_ACC;
          end else if (gp_q >= lim) begin
            st_d     = S_REL;
            gp_d     = gp_q + ONE;
            flag_set = 1'b1;
          end else begin
            gp_d = gp_q + ONE;
          end
        end
        S_REL: begin
          if (tone_valid) begin
            st_d     = S_ACC;
            flag_clr = 1'b1;
          end else if (gp_q + ONE >= pause) begin
            st_d = S_IDLE;
            clr  = 1'b1;
          end else begin
            gp_d = gp_q + ONE;
          end
        end
        default: st_d = S_IDLE;
      endcase
      if ((st_q == S_ACC || st_q == S_GAP2) && present_n && !flag_set) begin
        if (sp_q + ONE >= spd) flag_clr = 1'b1;
        else                   sp_d = sp_q + ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE;
      el_q <= '0;
      gp_q <= '0;
      sp_q <= '0;
      dg_q <= '0;
    end else begin
      st_q <= st_d;
      el_q <= el_d;
      gp_q <= gp_d;
      sp_q <= sp_d;
      dg_q <= dg_d;
    end
  end

  assign state     = st_q;
  assign load_data = dg_q;
endmodule

// File: rtl/dtmf_tq_outreg.sv
module dtmf_tq_outreg #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          clr,
  input  logic          flag_set,
  input  logic          flag_clr,
  output logic [DW-1:0] rx_data,
  output logic          present_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data   <= '0;
      present_n <= 1'b1;
    end else begin
      if (clr)       rx_data <= '0;
      else if (load) rx_data <= load_data;
      if (flag_set || clr) present_n <= 1'b1;
      else if (flag_clr)   present_n <= 1'b0;
    end
  end
endmodule

// File: rtl/dtmf_timing_qual.sv
module dtmf_timing_qual
  import dtmf_tq_pkg::*;
#(
  parameter int TW      = 8,
  parameter int DW      = 4,
  parameter int NRM_DET = 37, parameter int FST_DET = 24,
  parameter int NRM_REJ = 26, parameter int FST_REJ = 12,
  parameter int NRM_DR1 = 10, parameter int FST_DR1 = 10,
  parameter int NRM_DR2 = 20, parameter int FST_DR2 = 15,
  parameter int NRM_PAU = 30, parameter int FST_PAU = 24,
  parameter int NRM_SPD = 3,  parameter int FST_SPD = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          fast_mode,
  input  logic          tone_valid,
  input  logic [DW-1:0] tone_digit,
  output logic [DW-1:0] rx_data,
  output logic          present_n
);
  logic [TW-1:0] det, rej, drop1, drop2, pause, spd;
  qstate_t       st;
  logic          load, clr, flag_set, flag_clr;
  logic [DW-1:0] load_data;

  dtmf_tq_profile #(
    .TW(TW),
    .NRM_DET(NRM_DET), .FST_DET(FST_DET),
    .NRM_REJ(NRM_REJ), .FST_REJ(FST_REJ),
    .NRM_DR1(NRM_DR1), .FST_DR1(FST_DR1),
    .NRM_DR2(NRM_DR2), .FST_DR2(FST_DR2),
    .NRM_PAU(NRM_PAU), .FST_PAU(FST_PAU),
    .NRM_SPD(NRM_SPD), .FST_SPD(FST_SPD)
  ) u_prof (
    .clk(clk), .rst(rst), .fast_mode(fast_mode),
    .det(det), .rej(rej), .drop1(drop1), .drop2(drop2),
    .pause(pause), .spd(spd)
  );

  dtmf_tq_fsm #(.TW(TW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .tick(tick),
    .tone_valid(tone_valid), .tone_digit(tone_digit),
    .present_n(present_n),
    .det(det), .rej(rej), .drop1(drop1), .drop2(drop2),
    .pause(pause), .spd(spd),
    .state(st), .load(load), .load_data(load_data), .clr(clr),
    .flag_set(flag_set), .flag_clr(flag_clr)
  );

  dtmf_tq_outreg #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .load(load), .load_data(load_data),
    .clr(clr), .flag_set(flag_set), .flag_clr(flag_clr),
    .rx_data(rx_data), .present_n(present_n)
  );
endmodule

// File: rtl/dtmf_tq_checker.sv
module dtmf_tq_checker
  import dtmf_tq_pkg::*;
#(
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic [DW-1:0] rx_data,
  input logic          present_n,
  input qstate_t       state
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (present_n && rx_data == '0 && state == S_IDLE));

  assert_quiet_between_ticks_R11: assert property (@(posedge clk) disable iff (rst)
    (!tick && !$past(rst)) |=> ($stable(rx_data) && $stable(present_n)));

  assert_flag_low_only_accepted_R6: assert property (@(posedge clk) disable iff (rst)
    !present_n |-> (state == S_ACC || state == S_GAP2));

  assert_data_change_source_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(rx_data)) |->
      ($past(state) == S_QUAL || $past(state) == S_GAP1 || $past(state) == S_REL));

  assert_release_after_gap_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(present_n)) |-> ($past(state) == S_GAP2 || $past(state) == S_REL));

  assert_clear_only_in_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(rx_data) && rx_data == '0 && $past(state) == S_REL)
      |-> state == S_IDLE);
endmodule

bind dtmf_timing_qual dtmf_tq_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .rx_data(rx_data),
  .present_n(present_n), .state(st)
);

// File: tb/tb_dtmf_timing_qual.sv
module tb_dtmf_timing_qual;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       fast_mode = 1'b0;
  logic       tone_valid = 1'b0;
  logic [3:0] tone_digit = 4'd0;
  logic [3:0] rx_data;
  logic       present_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dtmf_timing_qual dut (
    .clk(clk), .rst(rst), .tick(tick), .fast_mode(fast_mode),
    .tone_valid(tone_valid), .tone_digit(tone_digit),
    .rx_data(rx_data), .present_n(present_n)
  );

  function automatic int det_of(input int m);  return m ? 24 : 37; endfunction
  function automatic int rej_of(input int m);  return m ? 12 : 26; endfunction
  function automatic int dr1_of(input int m);  return 10;          endfunction
  function automatic int dr2_of(input int m);  return m ? 15 : 20; endfunction
  function automatic int pau_of(input int m);  return m ? 24 : 30; endfunction
  function automatic int spd_of(input int m);  return 3;           endfunction

  task automatic step(input logic v, input logic [3:0] d);
    @(negedge clk);
    tone_valid = v;
    tone_digit = d;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(input logic v, input logic [3:0] d, input int n);
    for (int i = 0; i < n; i++) step(v, d);
  endtask

  task automatic expect_out(input string tag, input logic [3:0] ed, input logic en);
    checks++;
    if (rx_data !== ed || present_n !== en) begin
      errors++;
      $display("FAIL %s: rx_data=%0h present_n=%0b expected rx_data=%0h present_n=%0b",
               tag, rx_data, present_n, ed, en);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    expect_out("R1 during reset", 4'd0, 1'b1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    expect_out("R1 after reset", 4'd0, 1'b1);

    for (int m = 0; m < 2; m++) begin
      automatic string mt = m ? "R10 fast" : "R10 normal";
      fast_mode = m[0];
      repeat (4) @(negedge clk);

      // full acceptance, flag fall, hold and pause for every digit
      for (int d = 0; d < 16; d++) begin
        run(1'b1, d[3:0], det_of(m) - 1);
        expect_out({"R2 before det ", mt}, 4'd0, 1'b1);
        step(1'b1, d[3:0]);
        expect_out({"R2 at det ", mt}, d[3:0], 1'b1);
        run(1'b1, d[3:0], spd_of(m) - 1);
        expect_out({"R3 before spd ", mt}, d[3:0], 1'b1);
        step(1'b1, d[3:0]);
        expect_out({"R3 at spd ", mt}, d[3:0], 1'b0);
        run(1'b0, d[3:0], dr2_of(m));
        expect_out({"R6 gap at drop2 ", mt}, d[3:0], 1'b0);
        step(1'b0, d[3:0]);
        expect_out({"R7 hold expiry ", mt}, d[3:0], 1'b1);
        run(1'b0, d[3:0], pau_of(m) - dr2_of(m) - 2);
        expect_out({"R8 before pause ", mt}, d[3:0], 1'b1);
        step(1'b0, d[3:0]);
        expect_out({"R8 at pause ", mt}, 4'd0, 1'b1);
      end

      // short bursts are dropped
      for (int l = 1; l <= rej_of(m); l++) begin
        run(1'b1, 4'd5, l);
        expect_out({"R4 during burst ", mt}, 4'd0, 1'b1);
        run(1'b0, 4'd5, dr1_of(m) + 2);
        expect_out({"R4 after burst ", mt}, 4'd0, 1'b1);
      end

      // gap bridged before acceptance
      for (int g = 1; g <= dr1_of(m) && g <= det_of(m) - rej_of(m) - 2; g++) begin
        automatic int p = rej_of(m) + 1;
        run(1'b1, 4'd9, p);
        run(1'b0, 4'd9, g);
        run(1'b1, 4'd9, det_of(m) - p - g - 1);
        expect_out({"R5 bridge pending ", mt}, 4'd0, 1'b1);
        step(1'b1, 4'd9);
        expect_out({"R5 bridge accepted ", mt}, 4'd9, 1'b1);
        run(1'b0, 4'd9, pau_of(m));
        expect_out({"R8 clear after bridge ", mt}, 4'd0, 1'b1);
      end

      // gap of drop1+1 abandons qualification
      run(1'b1, 4'd7, rej_of(m) + 1);
      run(1'b0, 4'd7, dr1_of(m) + 1);
      expect_out({"R5 abandoned ", mt}, 4'd0, 1'b1);
      run(1'b1, 4'd7, det_of(m) - 1);
      expect_out({"R5 restart needs full det ", mt}, 4'd0, 1'b1);
      step(1'b1, 4'd7);
      expect_out({"R5 restart accepted ", mt}, 4'd7, 1'b1);
      run(1'b0, 4'd7, pau_of(m));
      expect_out({"R8 clear after restart ", mt}, 4'd0, 1'b1);

      // bridged gap after flag fall, then return after release
      run(1'b1, 4'd3, det_of(m) + spd_of(m));
      expect_out({"R3 flag low ", mt}, 4'd3, 1'b0);
      run(1'b0, 4'd3, dr2_of(m));
      step(1'b1, 4'd3);
      expect_out({"R6 bridged gap ", mt}, 4'd3, 1'b0);
      run(1'b0, 4'd3, dr2_of(m) + 1);
      expect_out({"R7 released ", mt}, 4'd3, 1'b1);
      step(1'b1, 4'd12);
      expect_out({"R9 return before pause ", mt}, 4'd3, 1'b0);
      run(1'b0, 4'd3, pau_of(m));
      expect_out({"R8 final clear ", mt}, 4'd0, 1'b1);
    end

    // reset in the middle of an accepted tone
    fast_mode = 1'b0;
    repeat (4) @(negedge clk);
    run(1'b1, 4'd4, det_of(0) + spd_of(0));
    expect_out("R3 before mid reset", 4'd4, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R1 mid reset", 4'd0, 1'b1);
    run(1'b1, 4'd4, det_of(0) - 1);
    expect_out("R1 timers restarted", 4'd0, 1'b1);
    step(1'b1, 4'd4);
    expect_out("R1 accepted after reset", 4'd4, 1'b1);

    // no tick: outputs frozen although input is absent
    tone_valid = 1'b0;
    repeat (20) @(negedge clk);
    expect_out("R11 frozen without tick", 4'd4, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule